// File: doc/BRIEF.md
# Display RAM Address Pointer Generator

This block holds the column pointer and the page pointer of a display memory organised as 128 columns by 8 pages of bytes. A command decoder upstream passes it the addressing mode, the column and page windows and the direct pointer loads. A host data port sends it one strobe per data byte, for a read or a write. For each strobe the block reports the address that the byte belongs to, raises a write strobe toward the memory when the byte is a write, and then moves its pointers on under the rule of the active mode.

Three rules are available. Horizontal mode walks along columns and steps to the next page when a row of the window is done. Vertical mode walks down pages and steps to the next column when a column of the window is done. Page mode walks along one page only, and the page changes only when software loads it. Both windows are inclusive ranges that can be programmed, and the pointers wrap back inside them.

Top module: `disp_ram_ptr_gen`

## Requirements
- R1: After synchronous reset the mode is page mode (code 2), both pointers are 0, the column window is 0..127, the page window is 0..7, the page-mode start column is 0 and `ram_we_o` is low.
- R2: `set_mode` with `mode_code` 0 selects horizontal, 1 vertical and 2 page mode. Code 3 is ignored and the previous mode stays active.
- R3: One cycle after `acc_stb`, `ram_we_o` equals `acc_wr`, and `ram_col_o`/`ram_page_o` hold the pointers from before the advance. In a cycle with no `acc_stb`, `ram_we_o` is low on the next cycle.
- R4: In horizontal mode each access adds one to the column. An access at the window's end column sends the column back to the start column and adds one to the page.
- R5: In horizontal mode an access with the column at its end and the page at its end sends both pointers back to their window starts.
- R6: In vertical mode each access adds one to the page. An access at the end page sends the page back to the start page and adds one to the column.
- R7: In vertical mode an access with the page at its end and the column at its end sends both pointers back to their window starts.
- R8: In page mode an access adds one to the column up to 127. An access at column 127 sends the column back to the page-mode start column. The page never changes on an access.
- R9: Loading the column window (`set_col_win`) moves the column pointer to the new start. Loading the page window (`set_page_win`) moves the page pointer to the new start. Both loads work in any mode.
- R10: In page mode, `set_col_lo` writes `col_nibble` into bits 3:0 of the start column and `set_col_hi` writes its low bits into bits 6:4. The column pointer takes the new start value. `set_page` moves the page pointer to `page_sel`.
- R11: Outside page mode, `set_col_lo`, `set_col_hi` and `set_page` are ignored and both pointers keep their values.
- R12: With no access and no load, both pointers hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_mode | input | 1 | Load the addressing mode |
| mode_code | input | 2 | Mode code: 0 horizontal, 1 vertical, 2 page |
| set_col_win | input | 1 | Load the column window |
| col_first | input | 7 | Column window start |
| col_last | input | 7 | Column window end |
| set_page_win | input | 1 | Load the page window |
| page_first | input | 3 | Page window start |
| page_last | input | 3 | Page window end |
| set_col_lo | input | 1 | Page mode: load the low nibble of the start column |
| set_col_hi | input | 1 | Page mode: load the high bits of the start column |
| col_nibble | input | 4 | Nibble value for the start-column loads |
| set_page | input | 1 | Page mode: load the page pointer |
| page_sel | input | 3 | Page value for `set_page` |
| acc_stb | input | 1 | One data byte is transferred this cycle |
| acc_wr | input | 1 | The transfer is a write (1) or a read (0) |
| col_o | output | 7 | Current column pointer |
| page_o | output | 3 | Current page pointer |
| ram_we_o | output | 1 | Registered write strobe toward the memory |
| ram_col_o | output | 7 | Column of the last transferred byte |
| ram_page_o | output | 3 | Page of the last transferred byte |

## Verification
The assertions take for granted that each window's start is no greater than its end, and that a load never falls in the same cycle as an access. The window-containment checks also expect the pointers to sit inside the window when horizontal or vertical mode is active. To stay within these limits, the stimulus loads both windows before it runs a horizontal or vertical walk. It drives every load in a cycle that has no access, and it uses only ordered windows. Page-mode walks start from a nibble-loaded column, so the wrap at column 127 is reached while the page stays fixed.

// File: rtl/disp_ptr_pkg.sv
package disp_ptr_pkg;
  typedef enum logic [1:0] {
    AM_HORZ = 2'd0,
    AM_VERT = 2'd1,
    AM_PAGE = 2'd2
  } addr_mode_e;
endpackage

// File: rtl/ptr_step.sv
// One wrapping counter step: next value inside [first, last].
module ptr_step #(
  parameter int W = 7
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] first,
  input  logic [W-1:0] last,
  output logic [W-1:0] nxt,
  output logic         at_end
);
  always_comb begin
    at_end = (cur == last);
    nxt    = at_end ? first : cur + W'(1);
  end
endmodule

// File: rtl/ptr_cfg_regs.sv
// Mode, window and page-mode start registers, plus pointer load requests.
module ptr_cfg_regs
  import disp_ptr_pkg::*;
#(
  parameter int CW = 7,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_mode,
  input  logic [1:0]    mode_code,
  input  logic          set_col_win,
  input  logic [CW-1:0] col_first,
  input  logic [CW-1:0] col_last,
  input  logic          set_page_win,
  input  logic [PW-1:0] page_first,
  input  logic [PW-1:0] page_last,
  input  logic          set_col_lo,
  input  logic          set_col_hi,
  input  logic [3:0]    col_nibble,
  input  logic          set_page,
  input  logic [PW-1:0] page_sel,
  output addr_mode_e    mode_q,
  output logic [CW-1:0] cs_q,
  output logic [CW-1:0] ce_q,
  output logic [PW-1:0] ps_q,
  output logic [PW-1:0] pe_q,
  output logic [CW-1:0] pm_start_q,
  output logic          col_ld,
  output logic [CW-1:0] col_ld_val,
  output logic          page_ld,
  output logic [PW-1:0] page_ld_val
);
  localparam int HIW = CW - 4;

  logic          in_page;
  logic          nib_lo_ok;
  logic          nib_hi_ok;
  logic [CW-1:0] pm_start_n;

  assign in_page   = (mode_q == AM_PAGE);
  assign nib_lo_ok = set_col_lo && in_page;
  assign nib_hi_ok = set_col_hi && in_page;

  generate
    if (HIW > 0) begin : g_split
      always_comb begin
        pm_start_n = pm_start_q;
        if (nib_lo_ok) pm_start_n[3:0]    = col_nibble;
        if (nib_hi_ok) pm_start_n[CW-1:4] = col_nibble[HIW-1:0];
      end
    end else begin : g_narrow
      always_comb begin
        pm_start_n = pm_start_q;
        if (nib_lo_ok) pm_start_n = col_nibble[CW-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= AM_PAGE;
      cs_q       <= '0;
      ce_q       <= '1;
      ps_q       <= '0;
      pe_q       <= '1;
      pm_start_q <= '0;
    end else begin
      if (set_mode && mode_code != 2'd3) mode_q <= addr_mode_e'(mode_code);
      if (set_col_win) begin
        cs_q <= col_first;
        ce_q <= col_last;
      end
      if (set_page_win) begin
        ps_q <= page_first;
        pe_q <= page_last;
      end
      pm_start_q <= pm_start_n;
    end
  end

  always_comb begin
    col_ld      = set_col_win || nib_lo_ok || nib_hi_ok;
    col_ld_val  = set_col_win ? col_first : pm_start_n;
    page_ld     = set_page_win || (set_page && in_page);
    page_ld_val = set_page_win ? page_first : page_sel;
  end
endmodule

// File: rtl/disp_ram_ptr_gen.sv
module disp_ram_ptr_gen
  import disp_ptr_pkg::*;
#(
  parameter int COLS  = 128,
  parameter int PAGES = 8,
  localparam int CW = $clog2(COLS),
  localparam int PW = $clog2(PAGES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_mode,
  input  logic [1:0]    mode_code,
  input  logic          set_col_win,
  input  logic [CW-1:0] col_first,
  input  logic [CW-1:0] col_last,
  input  logic          set_page_win,
  input  logic [PW-1:0] page_first,
  input  logic [PW-1:0] page_last,
  input  logic          set_col_lo,
  input  logic          set_col_hi,
  input  logic [3:0]    col_nibble,
  input  logic          set_page,
  input  logic [PW-1:0] page_sel,
  input  logic          acc_stb,
  input  logic          acc_wr,
  output logic [CW-1:0] col_o,
  output logic [PW-1:0] page_o,
  output logic          ram_we_o,
  output logic [CW-1:0] ram_col_o,
  output logic [PW-1:0] ram_page_o
);
  localparam logic [CW-1:0] COL_MAX = CW'(COLS - 1);

  addr_mode_e    mode_q;
  logic [CW-1:0] cs_q, ce_q, pm_start_q, col_ld_val;
  logic [PW-1:0] ps_q, pe_q, page_ld_val;
  logic          col_ld, page_ld;
  logic [CW-1:0] col_q, col_nx, col_first_eff, col_last_eff, col_n;
  logic [PW-1:0] page_q, page_nx, page_n;
  logic          col_end, page_end;

  ptr_cfg_regs #(.CW(CW), .PW(PW)) u_cfg (
    .clk(clk), .rst(rst),
    .set_mode(set_mode), .mode_code(mode_code),
    .set_col_win(set_col_win), .col_first(col_first), .col_last(col_last),
    .set_page_win(set_page_win), .page_first(page_first), .page_last(page_last),
    .set_col_lo(set_col_lo), .set_col_hi(set_col_hi), .col_nibble(col_nibble),
    .set_page(set_page), .page_sel(page_sel),
    .mode_q(mode_q), .cs_q(cs_q), .ce_q(ce_q), .ps_q(ps_q), .pe_q(pe_q),
    .pm_start_q(pm_start_q),
    .col_ld(col_ld), .col_ld_val(col_ld_val),
    .page_ld(page_ld), .page_ld_val(page_ld_val)
  );

  // page mode ignores the column window: full row, wrap to nibble start
  assign col_first_eff = (mode_q == AM_PAGE) ? pm_start_q : cs_q;
  assign col_last_eff  = (mode_q == AM_PAGE) ? COL_MAX    : ce_q;

  ptr_step #(.W(CW)) u_col_step (
    .cur(col_q), .first(col_first_eff), .last(col_last_eff),
    .nxt(col_nx), .at_end(col_end)
  );

  ptr_step #(.W(PW)) u_page_step (
    .cur(page_q), .first(ps_q), .last(pe_q),
    .nxt(page_nx), .at_end(page_end)
  );

  always_comb begin
    col_n  = col_q;
    page_n = page_q;
    unique case (mode_q)
      AM_HORZ: begin
        col_n  = col_nx;
        page_n = col_end ? page_nx : page_q;
      end
      AM_VERT: begin
        page_n = page_nx;
        col_n  = page_end ? col_nx : col_q;
      end
      default: col_n = col_nx;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q      <= '0;
      page_q     <= '0;
      ram_we_o   <= 1'b0;
      ram_col_o  <= '0;
      ram_page_o <= '0;
    end else begin
      ram_we_o <= acc_stb && acc_wr;
      if (acc_stb) begin
        ram_col_o  <= col_q;
        ram_page_o <= page_q;
      end
      if (col_ld)       col_q <= col_ld_val;
      else if (acc_stb) col_q <= col_n;
      if (page_ld)       page_q <= page_ld_val;
      else if (acc_stb)  page_q <= page_n;
    end
  end

  assign col_o  = col_q;
  assign page_o = page_q;

  // ---------------- assertions ----------------
  p_strobe_low_r3: assert property (@(posedge clk) disable iff (rst)
    !acc_stb |=> !ram_we_o);

  p_strobe_addr_r3: assert property (@(posedge clk) disable iff (rst)
    acc_stb |=> (ram_col_o == $past(col_o)) && (ram_page_o == $past(page_o)));

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!acc_stb && !col_ld && !page_ld) |=> $stable(col_o) && $stable(page_o));

  p_page_fixed_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == AM_PAGE && acc_stb && !page_ld && !set_mode) |=> $stable(page_o));

  p_horz_window_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == AM_HORZ && acc_stb && !col_ld && !set_mode && !set_col_win &&
     col_o >= cs_q && col_o <= ce_q) |=> (col_o >= cs_q && col_o <= ce_q));

  p_vert_col_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_q == AM_VERT && acc_stb && !col_ld && page_o != pe_q) |=> $stable(col_o));
endmodule

// File: tb/disp_ram_ptr_gen_bench.sv
module disp_ram_ptr_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       set_mode, set_col_win, set_page_win, set_col_lo, set_col_hi, set_page;
  logic [1:0] mode_code;
  logic [6:0] col_first, col_last;
  logic [2:0] page_first, page_last, page_sel;
  logic [3:0] col_nibble;
  logic       acc_stb, acc_wr;
  logic [6:0] col_o, ram_col_o;
  logic [2:0] page_o, ram_page_o;
  logic       ram_we_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_ram_ptr_gen u_disp_ram_ptr_gen (
    .clk(clk), .rst(rst),
    .set_mode(set_mode), .mode_code(mode_code),
    .set_col_win(set_col_win), .col_first(col_first), .col_last(col_last),
    .set_page_win(set_page_win), .page_first(page_first), .page_last(page_last),
    .set_col_lo(set_col_lo), .set_col_hi(set_col_hi), .col_nibble(col_nibble),
    .set_page(set_page), .page_sel(page_sel),
    .acc_stb(acc_stb), .acc_wr(acc_wr),
    .col_o(col_o), .page_o(page_o),
    .ram_we_o(ram_we_o), .ram_col_o(ram_col_o), .ram_page_o(ram_page_o)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic access(bit wr);
    acc_stb = 1'b1; acc_wr = wr;
    tick();
    acc_stb = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic load_mode(int code);
    set_mode = 1'b1; mode_code = 2'(code);
    tick();
    set_mode = 1'b0;
  endtask

  task automatic load_windows(int c0, int c1, int p0, int p1);
    set_col_win = 1'b1; col_first = 7'(c0); col_last = 7'(c1);
    set_page_win = 1'b1; page_first = 3'(p0); page_last = 3'(p1);
    tick();
    set_col_win = 1'b0; set_page_win = 1'b0;
  endtask

  task automatic test_reset();
    check("R1", "col", int'(col_o), 0);
    check("R1", "page", int'(page_o), 0);
    check("R1", "ram_we", int'(ram_we_o), 0);
  endtask

  // R8 page mode from reset, R3 strobe contents, R12 hold
  task automatic test_page_default();
    access(1'b1);
    check("R3", "ram_we after write", int'(ram_we_o), 1);
    check("R3", "ram_col", int'(ram_col_o), 0);
    access(1'b0);
    check("R3", "ram_we after read", int'(ram_we_o), 0);
    check("R8", "col after two", int'(col_o), 2);
    tick();
    check("R3", "ram_we idle", int'(ram_we_o), 0);
    tick();
    check("R12", "col hold", int'(col_o), 2);
    check("R12", "page hold", int'(page_o), 0);
  endtask

  // R10 nibble/page loads, R8 wrap at 127 to start column
  task automatic test_page_loads();
    set_col_lo = 1'b1; col_nibble = 4'hD; tick(); set_col_lo = 1'b0;
    set_col_hi = 1'b1; col_nibble = 4'h7; tick(); set_col_hi = 1'b0;
    check("R10", "col nibbles", int'(col_o), 125);
    set_page = 1'b1; page_sel = 3'd5; tick(); set_page = 1'b0;
    check("R10", "page load", int'(page_o), 5);
    access(1'b1); access(1'b1);
    check("R8", "col at 127", int'(col_o), 127);
    access(1'b1);
    check("R8", "wrap to start", int'(col_o), 125);
    check("R8", "page fixed", int'(page_o), 5);
    check("R3", "ram_col before wrap", int'(ram_col_o), 127);
  endtask

  // R2, R9, R4, R5, R11 horizontal walk
  task automatic test_horizontal();
    int ec[6] = '{11, 12, 10, 11, 12, 10};
    int ep[6] = '{2, 2, 3, 3, 3, 2};
    load_mode(0);
    load_windows(10, 12, 2, 3);
    check("R9", "col to start", int'(col_o), 10);
    check("R9", "page to start", int'(page_o), 2);
    set_page = 1'b1; page_sel = 3'd6;
    set_col_lo = 1'b1; col_nibble = 4'h1;
    tick();
    set_page = 1'b0; set_col_lo = 1'b0;
    check("R11", "page load ignored", int'(page_o), 2);
    check("R11", "nibble ignored", int'(col_o), 10);
    for (int i = 0; i < 6; i++) begin
      access(1'b1);
      check(i == 5 ? "R5" : "R4", "horz col", int'(col_o), ec[i]);
      check(i == 5 ? "R5" : "R4", "horz page", int'(page_o), ep[i]);
    end
  endtask

  // R2, R6, R7 vertical walk and invalid mode code
  task automatic test_vertical();
    int ec[4] = '{5, 6, 6, 5};
    int ep[4] = '{7, 6, 7, 6};
    load_mode(1);
    load_windows(5, 6, 6, 7);
    load_mode(3);
    for (int i = 0; i < 4; i++) begin
      access(1'b1);
      check(i == 3 ? "R7" : "R6", "vert col", int'(col_o), ec[i]);
      check(i == 3 ? "R7" : "R6", "vert page", int'(page_o), ep[i]);
    end
    check("R2", "mode 3 kept vertical", int'(page_o), 6);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    set_mode = 0; mode_code = 0; set_col_win = 0; col_first = 0; col_last = 0;
    set_page_win = 0; page_first = 0; page_last = 0;
    set_col_lo = 0; set_col_hi = 0; col_nibble = 0; set_page = 0; page_sel = 0;
    acc_stb = 0; acc_wr = 0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    test_reset();
    test_page_default();
    test_page_loads();
    test_horizontal();
    test_vertical();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule